// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder, 32 Bits

This block adds two 32-bit unsigned operands and a carry-in, giving a 32-bit sum and a carry-out. It is purely combinational, with no clock and no reset. The result is valid as soon as the inputs settle. It fits wherever a datapath needs a full-width add and cannot accept the delay of a ripple chain through all 32 bits.

The bits are split into eight 4-bit slices. Each slice forms per-bit propagate (`a xor b`) and generate (`a and b`). It works out its own internal carries from those, and it reports a group propagate and a group generate. Two lookahead units each take four slices, so each covers 16 bits. From the group signals and the carry into its half, a unit computes the carry into each of its slices and the carry out of its half, all as flat sum-of-products terms.

The two halves are joined end to end. The low unit's carry-out becomes the high unit's carry-in, and the high unit's carry-out is the block's carry-out.

Top module: `cla32_two_level`

## Requirements
- R1: For every input combination, `{carry_out, sum}` equals the 33-bit unsigned value `op_a + op_b + carry_in`.
- R2: With `op_b` zero, `sum` equals `op_a + carry_in` modulo 2^32. `carry_out` is 1 only when `op_a` is all ones and `carry_in` is 1.
- R3: When every bit of `op_a` differs from the matching bit of `op_b`, the carry-in passes through every position. `sum` is then all ones with `carry_out` 0 when `carry_in` is 0, and all zeros with `carry_out` 1 when `carry_in` is 1.
- R4: The carry from bit 15 into bit 16 comes from the low lookahead unit and equals the carry of the 16-bit sum `op_a[15:0] + op_b[15:0] + carry_in`. For example, 0x0000FFFF + 1 gives 0x00010000.
- R5: All-zero operands with `carry_in` 0 give `sum` 0 and `carry_out` 0.
- R6: The largest case, 0xFFFFFFFF + 0xFFFFFFFF + 1, gives `sum` 0xFFFFFFFF and `carry_out` 1.
- R7: `carry_out` is 1 exactly when the unsigned total exceeds 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand, unsigned |
| op_b | input | 32 | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of the total |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
The assertions are immediate checks. They assume the inputs carry only 0 and 1 values, and they skip any evaluation in which an operand or the carry-in is unknown. The bench drives every input to a defined value from time zero. It changes the inputs only once per clock, just after the rising edge, so the sum has settled well before the falling edge where it is compared.

// File: rtl/cla32_two_level.sv
module cla32_two_level (
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        carry_in,
  output logic [31:0] sum,
  output logic        carry_out
);
  localparam int SW    = 4;
  localparam int NS    = 8;
  localparam int SPH   = 4;
  localparam int NH    = NS / SPH;
  localparam int WIDTH = SW * NS;

  logic [WIDTH-1:0] p, g, c;
  logic [NS-1:0]    gp, gg, sc;
  logic [NH:0]      hc;

  assign p         = op_a ^ op_b;
  assign g         = op_a & op_b;
  assign sum       = p ^ c;
  assign hc[0]     = carry_in;
  assign carry_out = hc[NH];

  for (genvar k = 0; k < NS; k++) begin : g_slice
    localparam int B = k * SW;
    assign c[B]   = sc[k];
    assign c[B+1] = g[B] | (p[B] & sc[k]);
    assign c[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & sc[k]);
    assign c[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B])
                  | (p[B+2] & p[B+1] & p[B] & sc[k]);
    assign gp[k]  = &p[B +: SW];
    assign gg[k]  = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1])
                  | (p[B+3] & p[B+2] & p[B+1] & g[B]);
  end

  for (genvar h = 0; h < NH; h++) begin : g_lookahead
    localparam int J = h * SPH;
    assign sc[J]   = hc[h];
    assign sc[J+1] = gg[J] | (gp[J] & hc[h]);
    assign sc[J+2] = gg[J+1] | (gp[J+1] & gg[J]) | (gp[J+1] & gp[J] & hc[h]);
    assign sc[J+3] = gg[J+2] | (gp[J+2] & gg[J+1]) | (gp[J+2] & gp[J+1] & gg[J])
                   | (gp[J+2] & gp[J+1] & gp[J] & hc[h]);
    assign hc[h+1] = gg[J+3] | (gp[J+3] & gg[J+2]) | (gp[J+3] & gp[J+2] & gg[J+1])
                   | (gp[J+3] & gp[J+2] & gp[J+1] & gg[J])
                   | (gp[J+3] & gp[J+2] & gp[J+1] & gp[J] & hc[h]);
  end
endmodule

// File: rtl/cla32_two_level_chk.sv
module cla32_two_level_chk (
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        carry_in,
  input logic [31:0] sum,
  input logic        carry_out,
  input logic        mid_carry
);
  logic [32:0] full;
  logic [16:0] low;

  assign full = {1'b0, op_a} + {1'b0, op_b} + {32'd0, carry_in};
  assign low  = {1'b0, op_a[15:0]} + {1'b0, op_b[15:0]} + {16'd0, carry_in};

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      a_r1_exact_total: assert ({carry_out, sum} == full)
        else $error("R1 total wrong");
      a_r4_mid_carry: assert (mid_carry == low[16])
        else $error("R4 half carry wrong");
      a_r3_full_propagate: assert (((op_a ^ op_b) != 32'hFFFF_FFFF) ||
                                   (carry_out == carry_in && sum == {32{~carry_in}}))
        else $error("R3 propagate chain wrong");
      a_r2_zero_addend: assert ((op_b != 32'd0) || (sum == op_a + {31'd0, carry_in}))
        else $error("R2 zero addend wrong");
      a_r7_overflow_flag: assert (carry_out == (full > 33'h0_FFFF_FFFF))
        else $error("R7 carry-out wrong");
    end
  end
endmodule

bind cla32_two_level cla32_two_level_chk u_chk (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum(sum), .carry_out(carry_out), .mid_carry(hc[1])
);

// File: tb/cla32_two_level_tb.sv
module cla32_two_level_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0;
  logic [31:0] sum;
  logic        carry_out;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cla32_two_level u_dut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out)
  );

  task automatic check(input string req);
    longint unsigned tot;
    logic [32:0] exp;
    tot = longint'(op_a) + longint'(op_b) + longint'(carry_in);
    exp = tot[32:0];
    n_cmp++;
    if ({carry_out, sum} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h ci=%0d actual=%h_%h expected=%h_%h",
               req, op_a, op_b, carry_in, carry_out, sum, exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic ci, input string req);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; carry_in = ci;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset-time zero");
    rst = 1'b0;
    apply(32'h0, 32'h0, 1'b0, "R5 zero");
    apply(32'hFFFF_FFFF, 32'h1, 1'b0, "R7 all ones plus one");
    apply(32'h0000_FFFF, 32'h1, 1'b0, "R4 low half boundary");
    apply(32'h0000_FFFF, 32'h0, 1'b1, "R4 carry-in across bit 15");
    apply(32'h0000_7FFF, 32'h0000_8000, 1'b1, "R4 propagate through half");
    apply(32'hFFFF_FFFF, 32'h0, 1'b1, "R2 carry-in only");
    apply(32'h1234_5678, 32'h0, 1'b0, "R2 zero addend");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R3 propagate ci=0");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R3 propagate ci=1");
    apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1, "R3 mixed propagate");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6 maximum");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R7 top bit carry");
    apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R7 no carry-out");
    for (int i = 0; i < 16; i++) begin
      apply(32'h1 << (i * 2), 32'hFFFF_FFFF >> i, i[0], "R1 walking");
    end
    for (int i = 0; i < 2000; i++) begin
      apply($urandom, $urandom, 1'($urandom), "R1 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule